// File: doc/BRIEF.md
# Interleaved Multiphase PWM Generator

This block produces six single-ended pulse-width-modulated outputs, one for each half-bridge leg of a six-phase DC-DC converter. One free-running period counter sets the switching frequency. Each phase compares its own rotated copy of that count against an effective duty, so the six carriers sit one sixth of a period apart. Complementary gate signals and dead time are produced outside this block, by the gate drivers.

Each phase's duty is the sum of one shared base duty and a signed correction for that phase. The sum is limited to the range from zero to the full period. A slower control loop supplies the base duty and the six corrections and may change them at any moment. The block captures all of them together only at the period boundary, so a period never runs on a mix of old and new values.

With the default parameters, a 240 MHz logic clock and a 1200-count period give a 200 kHz switching frequency. The six phases are staggered by 200 counts.

Top module: `pwm_interleave_top`

## Requirements
- R1: An internal count runs 0, 1, ..., PERIOD-1 and then 0 again (PERIOD defaults to 1200). The outputs are registered. At the clock edge where the count holds c, bit k of `pwm_out` takes the value of ((c + k·PERIOD/6) mod PERIOD) < duty_k.
- R2: The carriers of the phases are staggered by PERIOD/6 = 200 counts. For phase k ≥ 1 with a duty strictly between 0 and PERIOD, the output rises at the edge where the count equals PERIOD − 200·k.
- R3: `duty_corr` bits [8k+7:8k] hold the correction for phase k, as an 8-bit two's-complement value. The effective duty is `base_duty` plus that correction, clamped to 0 at the bottom and to PERIOD at the top. Over one period, the output is high for exactly that many cycles.
- R4: An effective duty of 0 keeps the output low for the whole period. An effective duty of PERIOD keeps it high for the whole period.
- R5: All six effective duties are captured together, only at the edge where the count goes from PERIOD-1 to 0. A change to `base_duty` or `duty_corr` at any other time has no effect on the outputs until the next such edge.
- R6: While `en` is low at a clock edge, every output is low after that edge. The counter keeps running.
- R7: While `rst_n` is low, the outputs, the counter and the captured duties are zero. The first period after reset is released therefore has all outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Output enable; low forces all outputs low |
| base_duty | input | 11 | Shared base duty in counts, unsigned |
| duty_corr | input | 48 | Six 8-bit signed corrections; phase k at bits [8k+7:8k] |
| pwm_out | output | 6 | One PWM level per phase |

## Verification
The assertions take two things for granted. First, `rst_n` is released in step with the clock. Second, the duty inputs may carry any bit pattern, including a base above PERIOD or a correction that pushes the sum below zero, because the clamp absorbs both. The stimulus keeps within these assumptions: it drives every input only on the falling clock edge and releases reset on a falling edge. It draws base values from 0 to 1300 and corrections over the full signed 8-bit range, and it also changes the inputs in the middle of a period to exercise the capture rule.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Carrier rotation for phase k: an even share of the period per phase.
  function automatic int phase_offset(input int period, input int nphase, input int k);
    return (period / nphase) * k;
  endfunction

endpackage

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int PERIOD = 1200,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    wrap  = (cnt_q == CNT_W'(PERIOD - 1));
    cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(PERIOD));
  assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(PERIOD - 1)) |=> (cnt_q == '0));
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != CNT_W'(PERIOD - 1)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow #(
  parameter int NPHASE = 6,
  parameter int PERIOD = 1200,
  parameter int CORR_W = 8,
  parameter int DUTY_W = $clog2(PERIOD + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [DUTY_W-1:0]        base_duty,
  input  logic [NPHASE*CORR_W-1:0] duty_corr,
  output logic [NPHASE*DUTY_W-1:0] duty_flat
);

  localparam int WIDE  = (DUTY_W > CORR_W) ? DUTY_W : CORR_W;
  localparam int SUM_W = WIDE + 2;

  logic [DUTY_W-1:0] duty_d [NPHASE];
  logic [DUTY_W-1:0] duty_q [NPHASE];

  for (genvar g = 0; g < NPHASE; g++) begin : g_phase
    logic [CORR_W-1:0]       corr_raw;
    logic signed [SUM_W-1:0] sum;

    assign corr_raw = duty_corr[g*CORR_W +: CORR_W];

    always_comb begin
      sum = $signed({{(SUM_W-DUTY_W){1'b0}}, base_duty})
          + $signed({{(SUM_W-CORR_W){corr_raw[CORR_W-1]}}, corr_raw});
      if (sum[SUM_W-1])
        duty_d[g] = '0;
      else if (sum > $signed(SUM_W'(PERIOD)))
        duty_d[g] = DUTY_W'(PERIOD);
      else
        duty_d[g] = sum[DUTY_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    duty_q[g] <= '0;
      else if (load) duty_q[g] <= duty_d[g];
    end

    assign duty_flat[g*DUTY_W +: DUTY_W] = duty_q[g];

    assert_duty_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      duty_q[g] <= DUTY_W'(PERIOD));
  end

  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(duty_flat));

endmodule

// File: rtl/pwm_phase_cmp.sv
module pwm_phase_cmp #(
  parameter int PERIOD = 1200,
  parameter int OFFSET = 0,
  parameter int CNT_W  = $clog2(PERIOD),
  parameter int DUTY_W = $clog2(PERIOD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm
);

  logic [CNT_W:0]   rot;
  logic [CNT_W-1:0] phase_cnt;
  logic             pwm_d;
  logic             pwm_q;

  always_comb begin
    rot = {1'b0, cnt} + (CNT_W+1)'(OFFSET);
    if (rot >= (CNT_W+1)'(PERIOD)) rot = rot - (CNT_W+1)'(PERIOD);
    phase_cnt = rot[CNT_W-1:0];
    pwm_d     = en && (DUTY_W'(phase_cnt) < duty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm = pwm_q;

  assert_en_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_q);
  assert_zero_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |=> !pwm_q);
  assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && duty == DUTY_W'(PERIOD)) |=> pwm_q);

endmodule

// File: rtl/pwm_interleave_top.sv
module pwm_interleave_top #(
  parameter int NPHASE = 6,
  parameter int PERIOD = 1200,
  parameter int CORR_W = 8,
  localparam int DUTY_W = $clog2(PERIOD + 1),
  localparam int CNT_W  = $clog2(PERIOD)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [DUTY_W-1:0]        base_duty,
  input  logic [NPHASE*CORR_W-1:0] duty_corr,
  output logic [NPHASE-1:0]        pwm_out
);

  logic [CNT_W-1:0]         cnt;
  logic                     wrap;
  logic [NPHASE*DUTY_W-1:0] duty_flat;

  pwm_period_cnt #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap)
  );

  pwm_duty_shadow #(
    .NPHASE(NPHASE), .PERIOD(PERIOD), .CORR_W(CORR_W), .DUTY_W(DUTY_W)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(wrap),
    .base_duty(base_duty), .duty_corr(duty_corr), .duty_flat(duty_flat)
  );

  for (genvar g = 0; g < NPHASE; g++) begin : g_leg
    localparam int OFF = pwm_pkg::phase_offset(PERIOD, NPHASE, g);
    pwm_phase_cmp #(
      .PERIOD(PERIOD), .OFFSET(OFF), .CNT_W(CNT_W), .DUTY_W(DUTY_W)
    ) u_cmp (
      .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt),
      .duty(duty_flat[g*DUTY_W +: DUTY_W]), .pwm(pwm_out[g])
    );
  end

  assert_reset_low_R7: assert property (@(posedge clk)
    !rst_n |-> (pwm_out == '0));

endmodule

// File: tb/test_pwm_interleave_top.sv
module test_pwm_interleave_top;
  localparam int P   = 1200;
  localparam int N   = 6;
  localparam int CW  = 8;
  localparam int DW  = 11;
  localparam int OFF = P / N;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic [DW-1:0] base_duty;
  logic [N*CW-1:0] duty_corr;
  logic [N-1:0]  pwm_out;

  always #5 clk = ~clk;

  pwm_interleave_top i_pwm_interleave_top (
    .clk(clk), .rst_n(rst_n), .en(en), .base_duty(base_duty),
    .duty_corr(duty_corr), .pwm_out(pwm_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  int tb_b;
  int tb_c [N];
  bit tb_en;

  // Expected-value functions taken from the requirements.
  function automatic int clamp_duty(input int b, input int c);
    int s = b + c;
    if (s < 0) return 0;
    if (s > P) return P;
    return s;
  endfunction

  function automatic int phase_of(input int c, input int k);
    return (c + OFF * k) % P;
  endfunction

  // Cycle model of the timing rules (R1, R5, R6, R7).
  int m_cnt;
  int m_sh [N];
  logic [N-1:0] m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0;
      m_out <= '0;
      for (int k = 0; k < N; k++) m_sh[k] <= 0;
    end else begin
      for (int k = 0; k < N; k++) begin
        m_out[k] <= en && (phase_of(m_cnt, k) < m_sh[k]);
        if (m_cnt == P - 1)
          m_sh[k] <= clamp_duty(int'(base_duty),
                                int'($signed(duty_corr[k*CW +: CW])));
      end
      m_cnt <= (m_cnt == P - 1) ? 0 : m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n && !done) begin
      n_cmp++;
      if (pwm_out !== m_out) begin
        n_bad++;
        $display("FAIL R1 cycle compare cnt=%0d actual=%b expected=%b",
                 m_cnt, pwm_out, m_out);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive();
    en        = tb_en;
    base_duty = tb_b[DW-1:0];
    for (int k = 0; k < N; k++) duty_corr[k*CW +: CW] = tb_c[k][CW-1:0];
  endtask

  task automatic randomize_inputs();
    for (int k = 0; k < N; k++) begin
      logic [CW-1:0] r;
      r = CW'($urandom);
      tb_c[k] = int'($signed(r));
    end
    tb_b = int'($urandom_range(0, 1300));
  endtask

  // Collect one period of samples: sample i follows the edge where count = i.
  task automatic collect(output int hi [N], output int rise [N], input bit mid);
    logic [N-1:0] prev = '0;
    for (int k = 0; k < N; k++) begin hi[k] = 0; rise[k] = -1; end
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      for (int k = 0; k < N; k++) begin
        if (pwm_out[k]) hi[k]++;
        if (i > 0 && !prev[k] && pwm_out[k] && rise[k] < 0) rise[k] = i;
      end
      prev = pwm_out;
      if (mid && i == P / 2) begin
        randomize_inputs();
        drive();
      end
    end
  endtask

  task automatic run_window(input string req, input bit mid);
    int exp [N];
    int hi [N];
    int rise [N];
    for (int k = 0; k < N; k++) exp[k] = tb_en ? clamp_duty(tb_b, tb_c[k]) : 0;
    do @(negedge clk); while (m_cnt != 0);
    collect(hi, rise, mid);
    for (int k = 0; k < N; k++) begin
      chk($sformatf("%s high count phase %0d base %0d corr %0d", req, k, tb_b, tb_c[k]),
          hi[k], exp[k]);
      if (k > 0 && exp[k] > 0 && exp[k] < P)
        chk($sformatf("R2 rising edge phase %0d", k), rise[k], P - OFF * k);
    end
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    int hi [N];
    int rise [N];
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    tb_en = 1'b1; tb_b = 600;
    for (int k = 0; k < N; k++) tb_c[k] = 0;
    drive();
    repeat (3) @(negedge clk);
    chk("R7 outputs during reset", int'(pwm_out), 0);

    rst_n = 1'b1;
    model_on = 1'b1;
    collect(hi, rise, 1'b0);
    for (int k = 0; k < N; k++)
      chk($sformatf("R7 first period phase %0d", k), hi[k], 0);

    run_window("R1 nominal", 1'b0);

    tb_b = 500;
    tb_c[0] = -100; tb_c[1] = -50; tb_c[2] = 0;
    tb_c[3] = 50;   tb_c[4] = 100; tb_c[5] = 127;
    drive();
    run_window("R3 corrections", 1'b0);

    tb_b = 0; for (int k = 0; k < N; k++) tb_c[k] = 0;
    drive();
    run_window("R4 zero duty", 1'b0);

    tb_b = P;
    drive();
    run_window("R4 full duty", 1'b0);

    tb_b = 30; for (int k = 0; k < N; k++) tb_c[k] = -128 + 10 * k;
    drive();
    run_window("R3 clamp low", 1'b0);

    tb_b = 1150; for (int k = 0; k < N; k++) tb_c[k] = 40 + 15 * k;
    drive();
    run_window("R3 clamp high", 1'b0);

    tb_b = 1300; for (int k = 0; k < N; k++) tb_c[k] = -128;
    drive();
    run_window("R3 large base", 1'b0);

    tb_en = 1'b0; tb_b = 700;
    drive();
    run_window("R6 enable low", 1'b0);

    tb_en = 1'b1; tb_b = 300;
    for (int k = 0; k < N; k++) tb_c[k] = 20 * k - 40;
    drive();
    run_window("R5 mid-period change", 1'b1);
    run_window("R5 after capture", 1'b0);

    for (int n = 0; n < 16; n++) begin
      randomize_inputs();
      drive();
      run_window((n % 4 == 3) ? "R5 random mid change" : "R3 random", n % 4 == 3);
    end

    summary();
  end

endmodule